// File: doc/BRIEF.md
# Nibble-Immediate 8-bit Processor Core

This block is a small single-issue processor core. Its data path is 8 bits wide and it addresses 256 bytes. Every instruction is one byte and completes in one clock cycle. The core reads the byte at the program counter from a combinational instruction port. It changes its four registers, its compare flags and its program counter at the next rising edge. A store drives a one-cycle write strobe on the data memory port.

There is no way to read data memory back into a register. A full 8-bit constant is therefore built in the accumulator (register 0) in two steps. The first step loads the low nibble and clears the high nibble. The second step shifts the accumulator left by four and adds a further nibble. A compare sets exactly one of three flags: equal, higher or lower. The conditional jumps that follow read that flag. Once the halt instruction executes, the core stays frozen until reset.

Top module: `nib8_core`

## Requirements
- R1: While reset is low, the core behaves as follows. The instruction address is 0, `halted` is 0 and `dmem_we` is 0, even if the byte at address 0 is a store. After reset, all four registers are 0 and all flags are clear, so no conditional jump is taken.
- R2: An instruction byte is split into fields as follows. The opcode is bits [3:0] and the operand is bits [7:4]. In register form, the destination/second register Y is bits [7:6] and the source register X is bits [5:4]. Register index 0 is the accumulator.
- R3: Opcode 0x1 sets the accumulator to the zero-extended operand. Opcode 0x2 sets the accumulator to (accumulator << 4) + operand, modulo 256.
- R4: Opcode 0x3 copies register X into register Y.
- R5: Opcode 0x4 asserts `dmem_we` for that cycle only. It drives the accumulator onto `dmem_wdata` and drives the zero-extended operand onto `dmem_addr`. No other opcode writes.
- R6: Opcode 0x5 writes X+Y into Y and opcode 0x6 writes X−Y into Y, both modulo 256.
- R7: Opcode 0x7 writes X AND Y into Y. Opcode 0x9 writes X OR Y into Y. Opcode 0x8 writes the bitwise inverse of Y into Y.
- R8: Opcode 0xA compares X with Y as unsigned values. It sets exactly one flag: equal if X=Y, higher if X>Y, lower if X<Y. The flags keep their value until the next compare.
- R9: Opcode 0x0 loads the zero-extended operand into the program counter.
- R10: Opcodes 0xB, 0xC and 0xD jump to the zero-extended operand when the equal, higher or lower flag, respectively, is set. Otherwise the program counter advances by one.
- R11: Opcode 0xE raises `halted` after the edge that executes it. From then until reset, the instruction address holds the address of that instruction and no write occurs.
- R12: Opcode 0xF changes nothing except advancing the program counter by one, whatever its operand bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 8 | Program counter, address of the instruction being executed |
| imem_data | input | 8 | Instruction byte at `imem_addr`, valid in the same cycle |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_addr | output | 8 | Data memory write address |
| dmem_wdata | output | 8 | Data memory write data (accumulator) |
| halted | output | 1 | Core has executed a halt and is frozen |

## Verification
An error in the program counter shows on `imem_addr` one edge after the faulty instruction. A flag error shows the same way, one edge after the conditional jump that reads the flag. A register error stays hidden until the program moves that register into the accumulator and stores it. The directed programs therefore end each arithmetic step with such a store, so that a wrong result reaches `dmem_wdata` within two cycles. Every branch test places distinct stores on the taken and not-taken paths. It also fills unused program memory with halts, so a wrong target shows as both a wrong final address and a missing write.

// File: rtl/nib8_pkg.sv
`timescale 1ns/1ps
package nib8_pkg;

  localparam int DW     = 8;              // data path width
  localparam int AW     = 8;              // address width (both ports)
  localparam int IW     = 8;              // instruction width
  localparam int NIB    = 4;              // opcode / operand field width
  localparam int NREG   = 4;              // architectural registers
  localparam int RSEL_W = $clog2(NREG);   // register selector width

  typedef enum logic [NIB-1:0] {
    OP_JUMP   = 4'h0,
    OP_LDLO   = 4'h1,
    OP_SHLADD = 4'h2,
    OP_COPY   = 4'h3,
    OP_STORE  = 4'h4,
    OP_ADD    = 4'h5,
    OP_SUB    = 4'h6,
    OP_AND    = 4'h7,
    OP_INV    = 4'h8,
    OP_OR     = 4'h9,
    OP_CMP    = 4'hA,
    OP_BEQ    = 4'hB,
    OP_BGT    = 4'hC,
    OP_BLT    = 4'hD,
    OP_HALT   = 4'hE,
    OP_NOP    = 4'hF
  } op_e;

  typedef struct packed {
    logic eq;
    logic hi;
    logic lo;
  } flags_t;

  typedef struct packed {
    op_e               op;
    logic [NIB-1:0]    imm;
    logic [RSEL_W-1:0] ysel;
    logic [RSEL_W-1:0] xsel;
    logic              wr_y;    // result goes to register Y
    logic              wr_acc;  // result goes to the accumulator
    logic              store;
    logic              cmp;
    logic              branch;  // any jump, conditional or not
    logic              halt;
  } ctrl_t;

  // Register-to-register result; X is the left operand.
  function automatic logic [DW-1:0] alu_eval(op_e op, logic [DW-1:0] x, logic [DW-1:0] y);
    logic [DW-1:0] r;
    unique case (op)
      OP_ADD:  r = x + y;
      OP_SUB:  r = x - y;
      OP_AND:  r = x & y;
      OP_OR:   r = x | y;
      OP_INV:  r = ~y;
      default: r = x;              // copy
    endcase
    return r;
  endfunction

  function automatic logic [DW-1:0] nib_zext(logic [NIB-1:0] k);
    return {{(DW-NIB){1'b0}}, k};
  endfunction

  function automatic logic [DW-1:0] acc_shift_add(logic [DW-1:0] a, logic [NIB-1:0] k);
    return (a << NIB) + nib_zext(k);
  endfunction

  function automatic flags_t compare_eval(logic [DW-1:0] x, logic [DW-1:0] y);
    flags_t f;
    f.eq = (x == y);
    f.hi = (x > y);
    f.lo = (x < y);
    return f;
  endfunction

  function automatic logic branch_ok(op_e op, flags_t f);
    logic t;
    unique case (op)
      OP_JUMP: t = 1'b1;
      OP_BEQ:  t = f.eq;
      OP_BGT:  t = f.hi;
      OP_BLT:  t = f.lo;
      default: t = 1'b0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/nib8_decode.sv
`timescale 1ns/1ps
module nib8_decode
  import nib8_pkg::*;
(
  input  logic [IW-1:0] instr,
  output ctrl_t         ctrl
);

  op_e op;
  assign op = op_e'(instr[NIB-1:0]);

  always_comb begin
    ctrl        = '0;
    ctrl.op     = op;
    ctrl.imm    = instr[IW-1:NIB];
    ctrl.ysel   = instr[IW-1:IW-RSEL_W];
    ctrl.xsel   = instr[IW-RSEL_W-1:IW-2*RSEL_W];
    ctrl.wr_y   = (op == OP_COPY) || (op == OP_ADD) || (op == OP_SUB) ||
                  (op == OP_AND)  || (op == OP_INV) || (op == OP_OR);
    ctrl.wr_acc = (op == OP_LDLO) || (op == OP_SHLADD);
    ctrl.store  = (op == OP_STORE);
    ctrl.cmp    = (op == OP_CMP);
    ctrl.branch = (op == OP_JUMP) || (op == OP_BEQ) ||
                  (op == OP_BGT)  || (op == OP_BLT);
    ctrl.halt   = (op == OP_HALT);
  end

endmodule

// File: rtl/nib8_regfile.sv
`timescale 1ns/1ps
module nib8_regfile
  import nib8_pkg::*;
#(
  parameter int W  = DW,
  parameter int NR = NREG,
  localparam int SW = $clog2(NR)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] rsel_x,
  input  logic [SW-1:0] rsel_y,
  output logic [W-1:0]  rd_x,
  output logic [W-1:0]  rd_y,
  output logic [W-1:0]  rd_acc
);

  logic [W-1:0]  regs_q [NR];
  logic [NR-1:0] we_vec;

  for (genvar i = 0; i < NR; i++) begin : g_wsel
    assign we_vec[i] = we && (wsel == SW'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NR; i++) begin
      if (!rst_n)         regs_q[i] <= '0;
      else if (we_vec[i]) regs_q[i] <= wdata;
    end
  end

  assign rd_x   = regs_q[rsel_x];
  assign rd_y   = regs_q[rsel_y];
  assign rd_acc = regs_q[0];

endmodule

// File: rtl/nib8_exec.sv
`timescale 1ns/1ps
module nib8_exec
  import nib8_pkg::*;
#(
  parameter int W = DW,
  parameter int A = AW
)(
  input  ctrl_t             ctrl,
  input  logic              run,
  input  logic [W-1:0]      rd_x,
  input  logic [W-1:0]      rd_y,
  input  logic [W-1:0]      rd_acc,
  input  flags_t            flags_q,
  output logic              reg_we,
  output logic [RSEL_W-1:0] reg_wsel,
  output logic [W-1:0]      reg_wdata,
  output logic              flags_we,
  output flags_t            flags_d,
  output logic              take_jump,
  output logic [A-1:0]      target,
  output logic              halt_req,
  output logic              st_we,
  output logic [A-1:0]      st_addr,
  output logic [W-1:0]      st_data
);

  logic [A-1:0] imm_zext;
  assign imm_zext = {{(A-NIB){1'b0}}, ctrl.imm};

  // Write-back: the accumulator path serves the nibble loads, the ALU path the rest.
  always_comb begin
    reg_we    = run && (ctrl.wr_y || ctrl.wr_acc);
    reg_wsel  = ctrl.wr_acc ? '0 : ctrl.ysel;
    if (ctrl.wr_acc)
      reg_wdata = (ctrl.op == OP_LDLO) ? nib_zext(ctrl.imm) : acc_shift_add(rd_acc, ctrl.imm);
    else
      reg_wdata = alu_eval(ctrl.op, rd_x, rd_y);
  end

  assign flags_we  = run && ctrl.cmp;
  assign flags_d   = compare_eval(rd_x, rd_y);

  assign take_jump = run && ctrl.branch && branch_ok(ctrl.op, flags_q);
  assign target    = imm_zext;
  assign halt_req  = run && ctrl.halt;

  assign st_we     = run && ctrl.store;
  assign st_addr   = imm_zext;
  assign st_data   = rd_acc;

endmodule

// File: rtl/nib8_seq.sv
`timescale 1ns/1ps
module nib8_seq
  import nib8_pkg::*;
#(
  parameter int A = AW
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         halt_req,
  input  logic         take_jump,
  input  logic [A-1:0] target,
  output logic [A-1:0] pc,
  output logic         halted,
  output logic         ev_step
);

  logic [A-1:0] pc_q;
  logic         halted_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      if (halt_req)       halted_q <= 1'b1;
      else if (take_jump) pc_q     <= target;
      else                pc_q     <= pc_q + A'(1);
    end
  end

  assign pc      = pc_q;
  assign halted  = halted_q;
  assign ev_step = rst_n && !halted_q && !halt_req && !take_jump;

endmodule

// File: rtl/nib8_core.sv
`timescale 1ns/1ps
module nib8_core
  import nib8_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
)(
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [IW-1:0]     imem_data,
  output logic              dmem_we,
  output logic [ADDR_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  output logic              halted
);

  ctrl_t             ctrl;
  logic              run;
  logic [DATA_W-1:0] rd_x, rd_y, rd_acc;
  logic              reg_we;
  logic [RSEL_W-1:0] reg_wsel;
  logic [DATA_W-1:0] reg_wdata;
  logic              ev_cmp;    // a compare retires this cycle
  flags_t            flags_d;
  flags_t            flags_q;
  logic              ev_jump;   // program counter takes a jump target
  logic [ADDR_W-1:0] target;
  logic              halt_req;
  logic              ev_step;   // program counter advances by one
  logic              halted_q;

  assign run = rst_n && !halted_q;

  nib8_decode u_dec (
    .instr (imem_data),
    .ctrl  (ctrl)
  );

  nib8_regfile #(.W(DATA_W), .NR(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .wsel   (reg_wsel),
    .wdata  (reg_wdata),
    .rsel_x (ctrl.xsel),
    .rsel_y (ctrl.ysel),
    .rd_x   (rd_x),
    .rd_y   (rd_y),
    .rd_acc (rd_acc)
  );

  nib8_exec #(.W(DATA_W), .A(ADDR_W)) u_exe (
    .ctrl      (ctrl),
    .run       (run),
    .rd_x      (rd_x),
    .rd_y      (rd_y),
    .rd_acc    (rd_acc),
    .flags_q   (flags_q),
    .reg_we    (reg_we),
    .reg_wsel  (reg_wsel),
    .reg_wdata (reg_wdata),
    .flags_we  (ev_cmp),
    .flags_d   (flags_d),
    .take_jump (ev_jump),
    .target    (target),
    .halt_req  (halt_req),
    .st_we     (dmem_we),
    .st_addr   (dmem_addr),
    .st_data   (dmem_wdata)
  );

  // Flags live only here; nothing but a compare rewrites them.
  always_ff @(posedge clk) begin
    if (!rst_n)      flags_q <= '0;
    else if (ev_cmp) flags_q <= flags_d;
  end

  nib8_seq #(.A(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_req  (halt_req),
    .take_jump (ev_jump),
    .target    (target),
    .pc        (imem_addr),
    .halted    (halted_q),
    .ev_step   (ev_step)
  );

  assign halted = halted_q;

endmodule

// File: rtl/nib8_core_chk.sv
`timescale 1ns/1ps
module nib8_core_chk
  import nib8_pkg::*;
#(
  parameter int A = AW
)(
  input logic         clk,
  input logic         rst_n,
  input logic [A-1:0] imem_addr,
  input logic         dmem_we,
  input logic [A-1:0] dmem_addr,
  input logic         halted,
  input logic         ev_cmp,
  input logic         ev_jump,
  input logic         ev_step,
  input flags_t       flags_q
);

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R11
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(imem_addr));

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !dmem_we);

  // R5
  store_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> ((dmem_addr >> NIB) == '0));

  // R8
  flags_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp |=> ($countones(flags_q) == 1));

  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags_q));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_cmp |=> $stable(flags_q));

  // R9
  jump_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_jump |=> ((imem_addr >> NIB) == '0));

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> (imem_addr == A'($past(imem_addr) + A'(1))));

endmodule

bind nib8_core nib8_core_chk #(.A(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_addr (imem_addr),
  .dmem_we   (dmem_we),
  .dmem_addr (dmem_addr),
  .halted    (halted),
  .ev_cmp    (ev_cmp),
  .ev_jump   (ev_jump),
  .ev_step   (ev_step),
  .flags_q   (flags_q)
);

// File: tb/nib8_core_tb_top.sv
`timescale 1ns/1ps
module nib8_core_tb_top;

  localparam logic [3:0] K_JMP = 4'h0, K_LO = 4'h1, K_SHA = 4'h2, K_MOV = 4'h3,
                         K_ST  = 4'h4, K_ADD = 4'h5, K_SUB = 4'h6, K_AND = 4'h7,
                         K_INV = 4'h8, K_OR = 4'h9, K_CMP = 4'hA, K_BEQ = 4'hB,
                         K_BGT = 4'hC, K_BLT = 4'hD, K_HLT = 4'hE, K_NOP = 4'hF;
  localparam logic [7:0] SENT = 8'hEE;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] imem_addr, imem_data, dmem_addr, dmem_wdata;
  logic       dmem_we, halted;

  logic [7:0] imem [256];
  logic [7:0] dmem [256];
  int         wr_count;
  int         n_checks = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  nib8_core dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .halted     (halted)
  );

  assign imem_data = imem[imem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) dmem[i] <= SENT;
      wr_count <= 0;
    end else if (dmem_we) begin
      dmem[dmem_addr] <= dmem_wdata;
      wr_count <= wr_count + 1;
    end
  end

  function automatic logic [7:0] ei(logic [3:0] op, logic [3:0] k);
    return {k, op};
  endfunction

  function automatic logic [7:0] er(logic [3:0] op, logic [1:0] y, logic [1:0] x);
    return {y, x, op};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) imem[i] = ei(K_HLT, 4'h0);
  endtask

  task automatic start();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(string req, int final_pc);
    int n = 0;
    while (!halted && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(req, int'(halted), 1);
    chk(req, int'(imem_addr), final_pc);
  endtask

  // R1: reset state, zeroed registers and clear flags
  task automatic t_reset();
    clear_prog();
    imem[0]  = ei(K_ST, 4'h3);
    imem[1]  = er(K_MOV, 2'd0, 2'd1);
    imem[2]  = ei(K_ST, 4'h4);
    imem[3]  = er(K_MOV, 2'd0, 2'd2);
    imem[4]  = ei(K_ST, 4'h5);
    imem[5]  = er(K_MOV, 2'd0, 2'd3);
    imem[6]  = ei(K_ST, 4'h6);
    imem[7]  = ei(K_BEQ, 4'hF);
    imem[8]  = ei(K_BGT, 4'hF);
    imem[9]  = ei(K_BLT, 4'hF);
    imem[10] = ei(K_ST, 4'h7);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset pc", int'(imem_addr), 0);
    chk("R1 reset halted", int'(halted), 0);
    chk("R1 reset no write", int'(dmem_we), 0);
    rst_n = 1'b1;
    run_to_halt("R1 flags clear, no branch", 11);
    for (int a = 3; a <= 7; a++) chk("R1 register zero", int'(dmem[a]), 0);
    chk("R1 write count", wr_count, 5);
  endtask

  // R2 R3: nibble constant building
  task automatic t_const();
    clear_prog();
    imem[0] = ei(K_LO, 4'h5);
    imem[1] = ei(K_SHA, 4'hC);
    imem[2] = ei(K_ST, 4'h0);
    imem[3] = ei(K_LO, 4'h3);
    imem[4] = ei(K_ST, 4'h1);
    imem[5] = ei(K_SHA, 4'hF);
    imem[6] = ei(K_SHA, 4'hF);
    imem[7] = ei(K_ST, 4'h2);
    start();
    run_to_halt("R3 run", 8);
    chk("R3 low then shift-add", int'(dmem[0]), 8'h5C);
    chk("R3 low load clears high nibble", int'(dmem[1]), 8'h03);
    chk("R3 shift-add wraps", int'(dmem[2]), 8'hFF);
  endtask

  // R4 R6 R7 (and R2 field positions): register operations
  task automatic t_alu();
    int p = 0;
    clear_prog();
    imem[p++] = ei(K_LO, 4'hC);  imem[p++] = ei(K_SHA, 4'h8);
    imem[p++] = er(K_MOV, 2'd1, 2'd0);
    imem[p++] = ei(K_LO, 4'h5);  imem[p++] = ei(K_SHA, 4'hA);
    imem[p++] = er(K_MOV, 2'd2, 2'd0);
    imem[p++] = er(K_MOV, 2'd3, 2'd1);
    imem[p++] = er(K_ADD, 2'd3, 2'd2); imem[p++] = er(K_MOV, 2'd0, 2'd3); imem[p++] = ei(K_ST, 4'h0);
    imem[p++] = er(K_SUB, 2'd3, 2'd2); imem[p++] = er(K_MOV, 2'd0, 2'd3); imem[p++] = ei(K_ST, 4'h1);
    imem[p++] = er(K_SUB, 2'd1, 2'd2); imem[p++] = er(K_MOV, 2'd0, 2'd1); imem[p++] = ei(K_ST, 4'h2);
    imem[p++] = er(K_AND, 2'd2, 2'd1); imem[p++] = er(K_MOV, 2'd0, 2'd2); imem[p++] = ei(K_ST, 4'h3);
    imem[p++] = er(K_OR,  2'd3, 2'd1); imem[p++] = er(K_MOV, 2'd0, 2'd3); imem[p++] = ei(K_ST, 4'h4);
    imem[p++] = er(K_INV, 2'd1, 2'd0); imem[p++] = er(K_MOV, 2'd0, 2'd1); imem[p++] = ei(K_ST, 4'h5);
    imem[p++] = er(K_ADD, 2'd0, 2'd3); imem[p++] = ei(K_ST, 4'h6);
    start();
    run_to_halt("R4 run", p);
    chk("R6 add wraps", int'(dmem[0]), 8'h22);
    chk("R6 sub X-Y", int'(dmem[1]), 8'h38);
    chk("R6 sub borrow", int'(dmem[2]), 8'h92);
    chk("R7 and", int'(dmem[3]), 8'h12);
    chk("R7 or", int'(dmem[4]), 8'hBA);
    chk("R7 invert", int'(dmem[5]), 8'h6D);
    chk("R4 R6 accumulator as Y", int'(dmem[6]), 8'h27);
    chk("R5 write count", wr_count, 7);
  endtask

  // R5: store address range and data
  task automatic t_store();
    clear_prog();
    imem[0] = ei(K_LO, 4'h7);
    imem[1] = ei(K_ST, 4'hF);
    imem[2] = ei(K_LO, 4'h1);
    imem[3] = ei(K_SHA, 4'h2);
    imem[4] = ei(K_ST, 4'h0);
    start();
    run_to_halt("R5 run", 5);
    chk("R5 store top address", int'(dmem[15]), 8'h07);
    chk("R5 store address 0", int'(dmem[0]), 8'h12);
    chk("R5 nothing above 15", int'(dmem[16]), SENT);
    chk("R5 write count", wr_count, 2);
  endtask

  // R8 R10: compare then one conditional jump
  task automatic t_cond(string req, logic [3:0] xv, logic [3:0] yv, logic [3:0] jop, bit taken);
    clear_prog();
    imem[0]  = ei(K_LO, xv);
    imem[1]  = er(K_MOV, 2'd1, 2'd0);
    imem[2]  = ei(K_LO, yv);
    imem[3]  = er(K_MOV, 2'd2, 2'd0);
    imem[4]  = er(K_CMP, 2'd2, 2'd1);
    imem[5]  = ei(jop, 4'h9);
    imem[6]  = ei(K_ST, 4'h1);
    imem[9]  = ei(K_ST, 4'h2);
    start();
    run_to_halt(req, taken ? 10 : 7);
    chk(req, int'(dmem[taken ? 2 : 1]), int'(yv));
    chk(req, int'(dmem[taken ? 1 : 2]), SENT);
  endtask

  // R8: flags survive non-compare instructions; a later compare replaces them
  task automatic t_flags();
    clear_prog();
    imem[0] = ei(K_LO, 4'h4);
    imem[1] = er(K_MOV, 2'd1, 2'd0);
    imem[2] = er(K_CMP, 2'd1, 2'd0);
    imem[3] = er(K_ADD, 2'd1, 2'd0);
    imem[4] = er(K_MOV, 2'd0, 2'd1);
    imem[5] = ei(K_BEQ, 4'h8);
    imem[6] = ei(K_ST, 4'h1);
    imem[8] = ei(K_ST, 4'h2);
    start();
    run_to_halt("R8 flags persist", 9);
    chk("R8 flags persist data", int'(dmem[2]), 8'h08);

    clear_prog();
    imem[0]  = ei(K_LO, 4'h4);
    imem[1]  = er(K_MOV, 2'd1, 2'd0);
    imem[2]  = er(K_CMP, 2'd1, 2'd0);
    imem[3]  = ei(K_LO, 4'h6);
    imem[4]  = er(K_CMP, 2'd1, 2'd0);
    imem[5]  = ei(K_BEQ, 4'h9);
    imem[6]  = ei(K_BGT, 4'hB);
    imem[7]  = ei(K_ST, 4'h1);
    imem[9]  = ei(K_ST, 4'h2);
    imem[11] = ei(K_ST, 4'h3);
    start();
    run_to_halt("R8 compare replaces flags", 12);
    chk("R8 higher path data", int'(dmem[3]), 8'h06);
    chk("R8 write count", wr_count, 1);
  endtask

  // R9: unconditional jump skips code
  task automatic t_jump();
    clear_prog();
    imem[0] = ei(K_JMP, 4'h5);
    imem[1] = ei(K_ST, 4'h1);
    imem[5] = ei(K_LO, 4'h9);
    imem[6] = ei(K_ST, 4'h0);
    start();
    run_to_halt("R9 jump", 7);
    chk("R9 target code ran", int'(dmem[0]), 8'h09);
    chk("R9 skipped code", int'(dmem[1]), SENT);
  endtask

  // R12: no-operation with any operand
  task automatic t_nop();
    clear_prog();
    imem[0] = ei(K_LO, 4'h7);
    imem[1] = ei(K_NOP, 4'h0);
    imem[2] = ei(K_NOP, 4'hF);
    imem[3] = ei(K_NOP, 4'h3);
    imem[4] = ei(K_ST, 4'h0);
    start();
    @(negedge clk);
    chk("R12 pc after first step", int'(imem_addr), 1);
    run_to_halt("R12 nop run", 5);
    chk("R12 accumulator untouched", int'(dmem[0]), 8'h07);
    chk("R12 write count", wr_count, 1);
  endtask

  // R11: halt timing, freeze and release by reset
  task automatic t_halt();
    clear_prog();
    imem[0] = ei(K_LO, 4'h2);
    imem[1] = ei(K_HLT, 4'h0);
    imem[2] = ei(K_ST, 4'h0);
    start();
    @(negedge clk);
    chk("R11 not yet halted", int'(halted), 0);
    chk("R11 pc at halt", int'(imem_addr), 1);
    @(negedge clk);
    chk("R11 halted after edge", int'(halted), 1);
    repeat (40) @(negedge clk);
    chk("R11 still halted", int'(halted), 1);
    chk("R11 pc frozen", int'(imem_addr), 1);
    chk("R11 no write", wr_count, 0);
    chk("R11 memory untouched", int'(dmem[0]), SENT);
    start();
    chk("R1 reset clears halt", int'(halted), 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_prog();
    t_reset();
    t_const();
    t_alu();
    t_store();
    t_cond("R10 equal taken",       4'h5, 4'h5, K_BEQ, 1'b1);
    t_cond("R10 equal, higher not", 4'h5, 4'h5, K_BGT, 1'b0);
    t_cond("R10 equal, lower not",  4'h5, 4'h5, K_BLT, 1'b0);
    t_cond("R10 higher taken",      4'h9, 4'h2, K_BGT, 1'b1);
    t_cond("R10 higher, equal not", 4'h9, 4'h2, K_BEQ, 1'b0);
    t_cond("R10 lower taken",       4'h2, 4'h9, K_BLT, 1'b1);
    t_cond("R10 lower, higher not", 4'h2, 4'h9, K_BGT, 1'b0);
    t_flags();
    t_jump();
    t_nop();
    t_halt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule